// File: doc/BRIEF.md
# Peripheral Write-Protection Controller

This block sits between an APB bridge and a group of up to 32 peripherals, each of which owns a 1 KiB window. One protect bit is kept per peripheral. While the bit is set, a write aimed at that peripheral never reaches it: the select line to the peripheral stays low, and the bridge gets an error response. Reads always go through. A transfer marked as coming from the debugger skips the check, so the debugger can always update a protected peripheral.

Software changes protection through two register aliases on a separate configuration select. One alias sets bits and the other clears them, so no read-modify-write is needed. Ones in the written data name the peripherals to change. A request to protect a peripheral that is already protected, or to unprotect one that is already unprotected, counts as a program-flow fault. Such a request returns an error and changes nothing. Both aliases read back the current protection vector.

Top module: `wprot_ctrl`

## Requirements
- R1: After reset every protection bit is 0 (unprotected), no peripheral select is active, and both aliases read 0.
- R2: A write to the set alias (byte offset 0x4, decided by address bit 2 = 1) with no error sets each protection bit whose data bit is 1 and leaves bits written as 0 unchanged. The new value is visible from the next transfer.
- R3: A write to the clear alias (offset 0x0, address bit 2 = 0) with no error clears each protection bit whose data bit is 1 and leaves the others unchanged.
- R4: A read of either alias returns the protection vector in bits N-1:0. Both aliases return the same value.
- R5: A set-alias write that has a 1 in any bit already protected gives PSLVERR = 1 and updates no bit of that write.
- R6: A clear-alias write that has a 1 in any bit already unprotected gives PSLVERR = 1 and updates no bit of that write.
- R7: A non-debug write to a peripheral whose bit is set keeps all peripheral selects low. It completes in its access phase with PREADY = 1, PSLVERR = 1 and PRDATA = 0.
- R8: A write with `dbg_access` = 1 reaches the selected peripheral whatever its protection bit, and the peripheral's response is returned.
- R9: Reads of a protected peripheral are passed to it and its data and response are returned.
- R10: The slot is taken from address bits [14:10] (the bits above a 1 KiB window). An allowed window transfer drives exactly the select of that slot, which is index equal to the slot number.
- R11: Alias accesses have no wait states: PREADY = 1 in their access phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | APB clock |
| presetn | input | 1 | Active-low reset |
| paddr | input | 16 | Transfer address |
| pwrite | input | 1 | 1 = write |
| penable | input | 1 | APB access phase |
| pwdata | input | 32 | Write data |
| cfg_psel | input | 1 | Select for the alias registers |
| win_psel | input | 1 | Select for the peripheral windows |
| dbg_access | input | 1 | Transfer comes from the debugger |
| prdata | output | 32 | Read data to the bridge |
| pready | output | 1 | Transfer complete |
| pslverr | output | 1 | Error response |
| periph_sel | output | 32 | One select per peripheral |
| per_prdata | input | 32 | Read data from the selected peripheral |
| per_pready | input | 1 | Ready from the selected peripheral |
| per_pslverr | input | 1 | Error from the selected peripheral |

## Verification
Selects, read data, PREADY and PSLVERR are combinational in the access phase. The bench therefore samples them one time unit after the access-phase signals are driven, in the same cycle, and the monitor pops one expected item per access phase. A protection update is registered on the edge that ends the alias write, so the effect is due at the first transfer after it. The bench checks it with a later read or window access, never in the same cycle. The scoreboard keeps its own protection model, updated only for writes without error, to produce every expected value.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

  localparam int DATA_W = 32;

  typedef enum logic {
    ALIAS_CLR = 1'b0,
    ALIAS_SET = 1'b1
  } alias_e;

  typedef struct packed {
    logic [DATA_W-1:0] rdata;
    logic              ready;
    logic              slverr;
  } apb_rsp_t;

  // True when the request would re-apply a state a bit already has.
  function automatic logic redundant_change(input alias_e a,
                                            input logic [DATA_W-1:0] prot,
                                            input logic [DATA_W-1:0] mask);
    if (a == ALIAS_SET) return |(mask & prot);
    return |(mask & ~prot);
  endfunction

  function automatic logic [DATA_W-1:0] apply_change(input alias_e a,
                                                     input logic [DATA_W-1:0] prot,
                                                     input logic [DATA_W-1:0] mask);
    if (a == ALIAS_SET) return prot | mask;
    return prot & ~mask;
  endfunction

endpackage

// File: rtl/wprot_regs.sv
module wprot_regs
  import wprot_pkg::*;
#(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  alias_e       alias_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] prot_o,
  output logic         fault_o
);

  logic [N-1:0] prot_q;
  logic         change_fault;
  logic         change_ok;

  assign change_fault = wr_en && redundant_change(alias_i, DATA_W'(prot_q), DATA_W'(wdata_i));
  assign change_ok    = wr_en && !change_fault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q <= '0;
    end else if (change_ok) begin
      prot_q <= N'(apply_change(alias_i, DATA_W'(prot_q), DATA_W'(wdata_i)));
    end
  end

  assign prot_o  = prot_q;
  assign fault_o = change_fault;

  p_set_apply_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !fault_o && alias_i == ALIAS_SET) |=> (prot_q == ($past(prot_q) | $past(wdata_i))));

  p_clr_apply_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !fault_o && alias_i == ALIAS_CLR) |=> (prot_q == ($past(prot_q) & ~$past(wdata_i))));

  p_double_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && alias_i == ALIAS_SET && |(wdata_i & prot_q)) |-> fault_o);

  p_double_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && alias_i == ALIAS_CLR && |(wdata_i & ~prot_q)) |-> fault_o);

  p_fault_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |=> $stable(prot_q));

endmodule

// File: rtl/wprot_gate.sv
module wprot_gate
  import wprot_pkg::*;
#(
  parameter int N  = 32,
  parameter int SW = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic              dbg,
  input  logic [SW-1:0]     slot,
  input  logic [N-1:0]      prot,
  input  logic [DATA_W-1:0] per_prdata,
  input  logic              per_pready,
  input  logic              per_pslverr,
  output logic [N-1:0]      periph_sel,
  output apb_rsp_t          rsp
);

  logic [N-1:0] hit;
  logic         slot_ok;
  logic         prot_hit;
  logic         blocked;
  logic         refuse;

  for (genvar i = 0; i < N; i++) begin : g_slot
    assign hit[i]        = (slot == SW'(i));
    assign periph_sel[i] = win_psel && hit[i] && !blocked;
  end

  assign slot_ok  = |hit;
  assign prot_hit = |(hit & prot);
  assign blocked  = win_psel && pwrite && !dbg && prot_hit;
  assign refuse   = blocked || !slot_ok;

  always_comb begin
    if (refuse) begin
      rsp.rdata  = '0;
      rsp.ready  = 1'b1;
      rsp.slverr = 1'b1;
    end else begin
      rsp.rdata  = per_prdata;
      rsp.ready  = per_pready;
      rsp.slverr = per_pslverr;
    end
  end

  p_sel_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(periph_sel));

  p_block_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_psel && penable && pwrite && !dbg && prot_hit) |-> (periph_sel == '0 && rsp.slverr && rsp.ready));

  p_dbg_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (win_psel && pwrite && dbg && slot_ok) |-> (periph_sel != '0));

  p_read_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (win_psel && !pwrite && slot_ok) |-> ($countones(periph_sel) == 1));

endmodule

// File: rtl/wprot_ctrl.sv
module wprot_ctrl
  import wprot_pkg::*;
#(
  parameter int N           = 32,
  parameter int ADDR_W      = 16,
  parameter int SLOT_LSB    = 10,
  parameter int ALIAS_BIT   = 2
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic [ADDR_W-1:0] paddr,
  input  logic              pwrite,
  input  logic              penable,
  input  logic [DATA_W-1:0] pwdata,
  input  logic              cfg_psel,
  input  logic              win_psel,
  input  logic              dbg_access,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  output logic [N-1:0]      periph_sel,
  input  logic [DATA_W-1:0] per_prdata,
  input  logic              per_pready,
  input  logic              per_pslverr
);

  localparam int SW = $clog2(N);

  logic [N-1:0]  prot;
  logic          cfg_wr;
  logic          cfg_fault;
  alias_e        alias_sel;
  logic [SW-1:0] slot;
  apb_rsp_t      cfg_rsp;
  apb_rsp_t      win_rsp;
  apb_rsp_t      out_rsp;
  logic          unused_bits;

  assign alias_sel   = alias_e'(paddr[ALIAS_BIT]);
  assign slot        = paddr[SLOT_LSB +: SW];
  assign cfg_wr      = cfg_psel && penable && pwrite;
  assign unused_bits = ^{paddr, pwdata};

  wprot_regs #(.N(N)) u_regs (
    .clk     (pclk),
    .rst_n   (presetn),
    .wr_en   (cfg_wr),
    .alias_i (alias_sel),
    .wdata_i (pwdata[N-1:0]),
    .prot_o  (prot),
    .fault_o (cfg_fault)
  );

  wprot_gate #(.N(N), .SW(SW)) u_gate (
    .clk         (pclk),
    .rst_n       (presetn),
    .win_psel    (win_psel),
    .penable     (penable),
    .pwrite      (pwrite),
    .dbg         (dbg_access),
    .slot        (slot),
    .prot        (prot),
    .per_prdata  (per_prdata),
    .per_pready  (per_pready),
    .per_pslverr (per_pslverr),
    .periph_sel  (periph_sel),
    .rsp         (win_rsp)
  );

  always_comb begin
    cfg_rsp.rdata  = pwrite ? '0 : DATA_W'(prot);
    cfg_rsp.ready  = 1'b1;
    cfg_rsp.slverr = cfg_fault;
  end

  always_comb begin
    if (cfg_psel) begin
      out_rsp = cfg_rsp;
    end else if (win_psel) begin
      out_rsp = win_rsp;
    end else begin
      out_rsp = '{rdata: '0, ready: 1'b1, slverr: 1'b0};
    end
  end

  assign prdata  = out_rsp.rdata;
  assign pready  = out_rsp.ready;
  assign pslverr = out_rsp.slverr;

  p_cfg_nowait_r11: assert property (@(posedge pclk) disable iff (!presetn)
    (cfg_psel && penable) |-> pready);

  p_alias_read_r4: assert property (@(posedge pclk) disable iff (!presetn)
    (cfg_psel && !pwrite && penable) |-> (prdata[N-1:0] == prot));

  p_cfg_no_sel_r1: assert property (@(posedge pclk) disable iff (!presetn)
    (cfg_psel && !win_psel) |-> (periph_sel == '0));

endmodule

// File: tb/wprot_ctrl_test.sv
module wprot_ctrl_test;

  localparam int N = 32;

  typedef struct {
    string       tag;
    logic [31:0] sel;
    bit          chk_rd;
    logic [31:0] rd;
    logic        err;
  } exp_t;

  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic [15:0] paddr = '0;
  logic        pwrite = 1'b0;
  logic        penable = 1'b0;
  logic [31:0] pwdata = '0;
  logic        cfg_psel = 1'b0;
  logic        win_psel = 1'b0;
  logic        dbg_access = 1'b0;
  logic [31:0] prdata;
  logic        pready;
  logic        pslverr;
  logic [N-1:0] periph_sel;
  logic [31:0] per_prdata;

  int   checks = 0;
  int   errors = 0;
  exp_t sb[$];
  logic [31:0] mprot = '0;

  always #2.5 pclk = ~pclk;

  wprot_ctrl uut (
    .pclk (pclk), .presetn (presetn), .paddr (paddr), .pwrite (pwrite),
    .penable (penable), .pwdata (pwdata), .cfg_psel (cfg_psel),
    .win_psel (win_psel), .dbg_access (dbg_access), .prdata (prdata),
    .pready (pready), .pslverr (pslverr), .periph_sel (periph_sel),
    .per_prdata (per_prdata), .per_pready (1'b1), .per_pslverr (1'b0)
  );

  // Peripheral model: returns a tag plus the index of the selected slot.
  always_comb begin
    per_prdata = '0;
    for (int i = 0; i < N; i++)
      if (periph_sel[i]) per_prdata = 32'hA500_0000 + i;
  end

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Monitor: one expected item per access phase.
  initial begin
    forever begin
      @(negedge pclk);
      #1;
      if ((cfg_psel || win_psel) && penable) begin
        if (sb.size() == 0) begin
          check("scoreboard", "unexpected transfer", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(e.tag, "periph_sel", periph_sel, e.sel);
          check(e.tag, "pready (R11)", {31'd0, pready}, 32'd1);
          check(e.tag, "pslverr", {31'd0, pslverr}, {31'd0, e.err});
          if (e.chk_rd) check(e.tag, "prdata", prdata, e.rd);
        end
      end
    end
  end

  task automatic apb(input bit cfg, input bit wr, input logic [15:0] addr,
                     input logic [31:0] data, input bit dbg, input exp_t e);
    @(negedge pclk);
    cfg_psel = cfg; win_psel = !cfg; pwrite = wr; paddr = addr;
    pwdata = data; dbg_access = dbg; penable = 1'b0;
    @(negedge pclk);
    penable = 1'b1;
    sb.push_back(e);
    @(negedge pclk);
    cfg_psel = 1'b0; win_psel = 1'b0; penable = 1'b0; pwrite = 1'b0; dbg_access = 1'b0;
  endtask

  task automatic cfg_xfer(input string tag, input bit wr, input bit set_alias, input logic [31:0] data);
    exp_t e;
    e.tag = tag; e.sel = '0; e.chk_rd = !wr; e.rd = mprot; e.err = 1'b0;
    if (wr) begin
      e.err = set_alias ? |(data & mprot) : |(data & ~mprot);
      if (!e.err) mprot = set_alias ? (mprot | data) : (mprot & ~data);
    end
    apb(1'b1, wr, set_alias ? 16'h0004 : 16'h0000, data, 1'b0, e);
  endtask

  task automatic win_xfer(input string tag, input bit wr, input int slot, input bit dbg);
    exp_t e;
    bit   blk;
    blk = wr && mprot[slot] && !dbg;
    e.tag = tag; e.err = blk; e.chk_rd = !wr;
    e.sel = blk ? 32'd0 : (32'd1 << slot);
    e.rd  = blk ? 32'd0 : 32'hA500_0000 + slot;
    apb(1'b0, wr, 16'((slot << 10) | 8), 32'h1234_5678, dbg, e);
  endtask

  initial begin
    repeat (100000) @(posedge pclk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge pclk);
    @(negedge pclk);
    presetn = 1'b1;
    check("R1 reset", "periph_sel", periph_sel, 32'd0);
    cfg_xfer("R1 reset clr alias", 1'b0, 1'b0, 0);
    cfg_xfer("R1 reset set alias", 1'b0, 1'b1, 0);
    win_xfer("R10 write slot 3 open", 1'b1, 3, 1'b0);
    win_xfer("R10 read slot 7 open", 1'b0, 7, 1'b0);
    cfg_xfer("R2 set 3,7", 1'b1, 1'b1, 32'h0000_0088);
    cfg_xfer("R4 read set alias", 1'b0, 1'b1, 0);
    cfg_xfer("R4 read clr alias", 1'b0, 1'b0, 0);
    win_xfer("R7 write slot 3 blocked", 1'b1, 3, 1'b0);
    win_xfer("R7 write slot 7 blocked", 1'b1, 7, 1'b0);
    win_xfer("R10 write slot 4 open", 1'b1, 4, 1'b0);
    win_xfer("R9 read slot 3 protected", 1'b0, 3, 1'b0);
    win_xfer("R8 debug write slot 3", 1'b1, 3, 1'b1);
    cfg_xfer("R5 double protect", 1'b1, 1'b1, 32'h0000_0008);
    cfg_xfer("R5 mixed double protect", 1'b1, 1'b1, 32'h0000_0108);
    cfg_xfer("R5 readback unchanged", 1'b0, 1'b1, 0);
    cfg_xfer("R3 clear 7", 1'b1, 1'b0, 32'h0000_0080);
    cfg_xfer("R3 readback", 1'b0, 1'b0, 0);
    win_xfer("R3 slot 7 write passes", 1'b1, 7, 1'b0);
    cfg_xfer("R6 double unprotect", 1'b1, 1'b0, 32'h0000_0080);
    cfg_xfer("R6 mixed double unprotect", 1'b1, 1'b0, 32'h0000_0088);
    cfg_xfer("R6 readback unchanged", 1'b0, 1'b1, 0);
    cfg_xfer("R2 zero data no change", 1'b1, 1'b1, 32'h0000_0000);
    cfg_xfer("R2 set all others", 1'b1, 1'b1, 32'hFFFF_FFF7);
    cfg_xfer("R4 read all set", 1'b0, 1'b0, 0);
    win_xfer("R7 write slot 31 blocked", 1'b1, 31, 1'b0);
    win_xfer("R8 debug write slot 0", 1'b1, 0, 1'b1);
    win_xfer("R9 read slot 31 protected", 1'b0, 31, 1'b0);
    cfg_xfer("R3 clear all", 1'b1, 1'b0, 32'hFFFF_FFFF);
    cfg_xfer("R4 read cleared", 1'b0, 1'b1, 0);
    win_xfer("R10 write slot 31 open", 1'b1, 31, 1'b0);
    repeat (2) @(negedge pclk);
    check("scoreboard", "items left", sb.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule